// File: doc/BRIEF.md
# Vector Slide-by-One with Scalar Insert

This block moves every element of a short vector one lane up or one lane down and puts a scalar value into the lane left empty. In the upward direction the scalar lands in lane 0. In the downward direction it lands in the last active lane, which is set by an active-element count. Each lane is written only if it is enabled by a per-lane mask and lies inside the window from a start position up to the active count. Every other lane keeps the value taken from the old destination vector.

A start strobe samples all operands into internal registers. On the next clock edge the block either writes the result and pulses `doneOut`, or finds a rule violation, writes nothing and pulses `illegalOut`. A start position register follows the operation. It loads the requested start lane when the operation is accepted and returns to zero only when the operation completes.

Top module: `vec_slide1`

## Requirements
- R1: While `rstN` is low, `resVec`, `curStart`, `doneOut` and `illegalOut` are all zero.
- R2: A start sampled with the block idle gives exactly one of `doneOut` or `illegalOut`, high for one cycle. It rises at the next rising edge, and `resVec` updates at that same edge.
- R3: With `slideDown`=0, a written lane 0 takes `scalarIn`, and a written lane i>0 takes lane i-1 of `srcVec` (lane i sits at bits [i*SEW +: SEW]).
- R4: With `slideDown`=1, a written lane i below `activeCnt`-1 takes lane i+1 of `srcVec`, and lane `activeCnt`-1 takes `scalarIn`.
- R5: With `maskEn`=1, only lanes whose `maskBits` bit is 1 are written. With `maskEn`=0, `maskBits` has no effect and every lane in the window is written. A lane that is not written shows its `oldDst` value in `resVec`.
- R6: Only lanes i with `startPos` <= i < `activeCnt` are written. Lanes outside that window show their `oldDst` value.
- R7: `slideDown`=0 with `srcIdx`==`dstIdx` is illegal: `illegalOut` pulses, `doneOut` stays low and `resVec` is unchanged. `slideDown`=1 with equal indices is legal.
- R8: `activeCnt` greater than NUM_ELEM is illegal in either direction, with the same effect as in R7. `activeCnt`=0 is legal, writes no lane and still pulses `doneOut`.
- R9: `curStart` takes `startPos` at the edge that accepts a start. It becomes zero at the edge where `doneOut` rises, and keeps its value after an illegal operation.
- R10: The result depends only on operand values sampled with the start. Changes to `srcVec`, `scalarIn`, `oldDst`, the mask inputs or the indices after that edge have no effect.
- R11: A start presented during the cycle after an accepted start is ignored, so only one outcome pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Start strobe, samples all operands |
| slideDown | input | 1 | 0 = move lanes up, 1 = move lanes down |
| srcVec | input | NUM_ELEM*SEW | Source vector, lane i at [i*SEW +: SEW] |
| scalarIn | input | SEW | Scalar placed in the vacated lane |
| maskBits | input | NUM_ELEM | Per-lane write enable |
| maskEn | input | 1 | 1 = apply maskBits, 0 = all lanes enabled |
| oldDst | input | NUM_ELEM*SEW | Prior destination contents |
| srcIdx | input | IDX_W | Source register index |
| dstIdx | input | IDX_W | Destination register index |
| activeCnt | input | CNT_W | Number of active lanes |
| startPos | input | CNT_W | First lane eligible for writing |
| resVec | output | NUM_ELEM*SEW | Result vector register |
| curStart | output | CNT_W | Start position register |
| doneOut | output | 1 | One-cycle completion pulse |
| illegalOut | output | 1 | One-cycle rule-violation pulse |

## Verification
A fault in the operand capture or in the lane selection appears in `resVec` at the outcome edge, one cycle after the start, as a single wrong lane. A stale busy flag shows at the ports as a missing or doubled outcome pulse in that cycle or the next. A wrong rule decision swaps `doneOut` and `illegalOut` and leaves either a changed or a frozen `resVec`. The reference model is compared with every output on every cycle, so each of these faults is reported within two cycles of its cause.

// File: rtl/vec_slide1_pkg.sv
package vec_slide1_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capture; // sample operands, load start position
    logic commit;  // write result, clear start position
    logic reject;  // rule violated, keep result
  } slideStrobes_t;
endpackage

// File: rtl/vec_slide1_ctrl.sv
module vec_slide1_ctrl
  import vec_slide1_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          startIn,
  input  logic          ruleBad,
  output slideStrobes_t stb,
  output logic          doneOut,
  output logic          illegalOut
);
  logic busy;

  always_comb begin
    stb.capture = startIn && !busy;
    stb.commit  = busy && !ruleBad;
    stb.reject  = busy && ruleBad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      doneOut    <= 1'b0;
      illegalOut <= 1'b0;
    end else begin
      busy       <= stb.capture;
      doneOut    <= stb.commit;
      illegalOut <= stb.reject;
    end
  end

  assert_single_outcome_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(doneOut && illegalOut));
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);
  assert_outcome_after_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut || illegalOut) |-> $past(busy));
  assert_start_blocked_R11: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);
endmodule

// File: rtl/vec_slide1_dp.sv
module vec_slide1_dp
  import vec_slide1_pkg::*;
#(
  parameter int NUM_ELEM = 8,
  parameter int SEW      = 16,
  parameter int IDX_W    = 5,
  parameter int CNT_W    = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  slideStrobes_t           stb,
  input  logic                    slideDown,
  input  logic [NUM_ELEM*SEW-1:0] srcVec,
  input  logic [SEW-1:0]          scalarIn,
  input  logic [NUM_ELEM-1:0]     maskBits,
  input  logic                    maskEn,
  input  logic [NUM_ELEM*SEW-1:0] oldDst,
  input  logic [IDX_W-1:0]        srcIdx,
  input  logic [IDX_W-1:0]        dstIdx,
  input  logic [CNT_W-1:0]        activeCnt,
  input  logic [CNT_W-1:0]        startPos,
  output logic                    ruleBad,
  output logic [NUM_ELEM*SEW-1:0] resVec,
  output logic [CNT_W-1:0]        curStart
);
  localparam int VEC_W = NUM_ELEM * SEW;

  logic [VEC_W-1:0]    srcQ, oldQ, nextRes;
  logic [SEW-1:0]      scalarQ;
  logic [NUM_ELEM-1:0] laneEnQ;
  logic                downQ, sameIdxQ;
  logic [CNT_W-1:0]    cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ     <= '0;
      oldQ     <= '0;
      scalarQ  <= '0;
      laneEnQ  <= '0;
      downQ    <= 1'b0;
      sameIdxQ <= 1'b0;
      cntQ     <= '0;
    end else if (stb.capture) begin
      srcQ     <= srcVec;
      oldQ     <= oldDst;
      scalarQ  <= scalarIn;
      laneEnQ  <= maskEn ? maskBits : '1;
      downQ    <= slideDown;
      sameIdxQ <= (srcIdx == dstIdx);
      cntQ     <= activeCnt;
    end
  end

  assign ruleBad = (!downQ && sameIdxQ) || (cntQ > CNT_W'(NUM_ELEM));

  for (genvar g = 0; g < NUM_ELEM; g++) begin : gLane
    logic [SEW-1:0] upVal, downVal;
    logic           inWin;

    if (g == 0) begin : gFirst
      assign upVal = scalarQ;
    end else begin : gRest
      assign upVal = srcQ[(g-1)*SEW +: SEW];
    end

    if (g == NUM_ELEM - 1) begin : gLast
      assign downVal = scalarQ;
    end else begin : gInner
      assign downVal = (cntQ == CNT_W'(g + 1)) ? scalarQ : srcQ[(g+1)*SEW +: SEW];
    end

    assign inWin = (CNT_W'(g) >= curStart) && (CNT_W'(g) < cntQ);

    assign nextRes[g*SEW +: SEW] = (inWin && laneEnQ[g])
                                 ? (downQ ? downVal : upVal)
                                 : oldQ[g*SEW +: SEW];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resVec   <= '0;
      curStart <= '0;
    end else begin
      if (stb.commit) begin
        resVec   <= nextRes;
        curStart <= '0;
      end else if (stb.capture) begin
        curStart <= startPos;
      end
    end
  end

  assert_start_cleared_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> (curStart == '0));
  assert_start_loaded_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> (curStart == $past(startPos)));
  assert_reject_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.reject |=> ($stable(resVec) && $stable(curStart)));
  assert_count_bounded_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> (cntQ <= CNT_W'(NUM_ELEM)));
endmodule

// File: rtl/vec_slide1.sv
module vec_slide1
  import vec_slide1_pkg::*;
#(
  parameter int NUM_ELEM = 8,
  parameter int SEW      = 16,
  parameter int IDX_W    = 5,
  localparam int CNT_W   = $clog2(NUM_ELEM + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startIn,
  input  logic                    slideDown,
  input  logic [NUM_ELEM*SEW-1:0] srcVec,
  input  logic [SEW-1:0]          scalarIn,
  input  logic [NUM_ELEM-1:0]     maskBits,
  input  logic                    maskEn,
  input  logic [NUM_ELEM*SEW-1:0] oldDst,
  input  logic [IDX_W-1:0]        srcIdx,
  input  logic [IDX_W-1:0]        dstIdx,
  input  logic [CNT_W-1:0]        activeCnt,
  input  logic [CNT_W-1:0]        startPos,
  output logic [NUM_ELEM*SEW-1:0] resVec,
  output logic [CNT_W-1:0]        curStart,
  output logic                    doneOut,
  output logic                    illegalOut
);
  slideStrobes_t stb;
  logic          ruleBad;

  vec_slide1_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .ruleBad(ruleBad),
    .stb(stb), .doneOut(doneOut), .illegalOut(illegalOut)
  );

  vec_slide1_dp #(
    .NUM_ELEM(NUM_ELEM), .SEW(SEW), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .slideDown(slideDown),
    .srcVec(srcVec), .scalarIn(scalarIn), .maskBits(maskBits), .maskEn(maskEn),
    .oldDst(oldDst), .srcIdx(srcIdx), .dstIdx(dstIdx), .activeCnt(activeCnt),
    .startPos(startPos), .ruleBad(ruleBad), .resVec(resVec), .curStart(curStart)
  );
endmodule

// File: tb/test_vec_slide1.sv
module test_vec_slide1;
  localparam int N = 8;
  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startIn = 1'b0, slideDown = 1'b0, maskEn = 1'b0;
  logic [N*W-1:0] srcVec = '0, oldDst = '0;
  logic [W-1:0]  scalarIn = '0;
  logic [N-1:0]  maskBits = '0;
  logic [4:0]    srcIdx = '0, dstIdx = '0;
  logic [3:0]    activeCnt = '0, startPos = '0;
  logic [N*W-1:0] resVec;
  logic [3:0]    curStart;
  logic          doneOut, illegalOut;

  int    checks = 0, fails = 0;
  string curReq = "R1";
  bit    finished = 0;

  always #10 clk = ~clk;

  vec_slide1 i_vec_slide1 (
    .clk(clk), .rstN(rstN), .startIn(startIn), .slideDown(slideDown),
    .srcVec(srcVec), .scalarIn(scalarIn), .maskBits(maskBits), .maskEn(maskEn),
    .oldDst(oldDst), .srcIdx(srcIdx), .dstIdx(dstIdx), .activeCnt(activeCnt),
    .startPos(startPos), .resVec(resVec), .curStart(curStart),
    .doneOut(doneOut), .illegalOut(illegalOut)
  );

  // behavioural reference
  logic [W-1:0] mSrc[N], mOld[N], mRes[N];
  logic [W-1:0] mScal;
  bit           mEn[N];
  bit           mDown, mSame, mBusy, mDone, mIll;
  int           mCnt, mStart;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) mRes[i] = '0;
      mBusy = 0; mDone = 0; mIll = 0; mStart = 0;
    end else if (mBusy) begin
      mBusy = 0;
      if ((!mDown && mSame) || mCnt > N) begin
        mIll = 1; mDone = 0;
      end else begin
        for (int i = 0; i < N; i++) begin
          if (i >= mStart && i < mCnt && mEn[i]) begin
            if (mDown) mRes[i] = (i == mCnt - 1) ? mScal : mSrc[i + 1];
            else       mRes[i] = (i == 0) ? mScal : mSrc[i - 1];
          end else begin
            mRes[i] = mOld[i];
          end
        end
        mDone = 1; mIll = 0; mStart = 0;
      end
    end else begin
      mDone = 0; mIll = 0;
      if (startIn) begin
        for (int i = 0; i < N; i++) begin
          mSrc[i] = srcVec[i*W +: W];
          mOld[i] = oldDst[i*W +: W];
          mEn[i]  = maskEn ? maskBits[i] : 1'b1;
        end
        mScal = scalarIn; mDown = slideDown; mSame = (srcIdx == dstIdx);
        mCnt = int'(activeCnt); mStart = int'(startPos); mBusy = 1;
      end
    end
  end

  task automatic chk(string what, logic [N*W-1:0] act, logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic [N*W-1:0] packed_exp;
      for (int i = 0; i < N; i++) packed_exp[i*W +: W] = mRes[i];
      chk("resVec", resVec, packed_exp);
      chk("doneOut", {{(N*W-1){1'b0}}, doneOut}, {{(N*W-1){1'b0}}, mDone});
      chk("illegalOut", {{(N*W-1){1'b0}}, illegalOut}, {{(N*W-1){1'b0}}, mIll});
      chk("curStart", {{(N*W-4){1'b0}}, curStart}, {{(N*W-4){1'b0}}, 4'(mStart)});
    end
  end

  function automatic logic [N*W-1:0] mkVec(logic [W-1:0] seed);
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = seed + W'(i * 16'h0111);
    return v;
  endfunction

  task automatic runOp(string req, bit dn, logic [W-1:0] sSeed, logic [W-1:0] scal,
                       bit mEnIn, logic [N-1:0] mBits, logic [W-1:0] oSeed,
                       logic [4:0] si, logic [4:0] di, logic [3:0] cnt,
                       logic [3:0] spos, bit holdTwo);
    @(negedge clk);
    curReq = req;
    slideDown = dn; srcVec = mkVec(sSeed); scalarIn = scal; maskEn = mEnIn;
    maskBits = mBits; oldDst = mkVec(oSeed); srcIdx = si; dstIdx = di;
    activeCnt = cnt; startPos = spos; startIn = 1'b1;
    @(negedge clk);
    startIn = holdTwo;
    // R10: scramble operands after capture
    srcVec = ~srcVec; scalarIn = ~scalarIn; oldDst = ~oldDst;
    maskBits = ~maskBits; maskEn = ~maskEn; srcIdx = ~srcIdx;
    slideDown = ~slideDown; activeCnt = activeCnt ^ 4'd3; startPos = 4'd0;
    @(negedge clk);
    startIn = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    chk("reset resVec", resVec, '0);
    chk("reset flags/start", {{(N*W-6){1'b0}}, doneOut, illegalOut, curStart}, '0);
    rstN = 1'b1;
    @(negedge clk);
    runOp("R3", 0, 16'h1000, 16'hAAAA, 0, 8'h00, 16'h5000, 5'd1, 5'd2, 4'd8, 4'd0, 0);
    runOp("R4", 1, 16'h2000, 16'hBBBB, 0, 8'h00, 16'h6000, 5'd3, 5'd4, 4'd8, 4'd0, 0);
    runOp("R4", 1, 16'h2100, 16'hCCCC, 0, 8'h00, 16'h6100, 5'd3, 5'd4, 4'd5, 4'd0, 0);
    runOp("R5", 0, 16'h3000, 16'hDDDD, 1, 8'hA6, 16'h7000, 5'd1, 5'd2, 4'd8, 4'd0, 0);
    runOp("R5", 1, 16'h3100, 16'hEEEE, 1, 8'h59, 16'h7100, 5'd1, 5'd2, 4'd8, 4'd0, 0);
    runOp("R5", 1, 16'h3200, 16'h1111, 0, 8'h00, 16'h7200, 5'd1, 5'd2, 4'd7, 4'd0, 0);
    runOp("R6", 0, 16'h4000, 16'h2222, 0, 8'h00, 16'h8000, 5'd1, 5'd2, 4'd6, 4'd3, 0);
    runOp("R6", 1, 16'h4100, 16'h3333, 0, 8'h00, 16'h8100, 5'd1, 5'd2, 4'd6, 4'd2, 0);
    runOp("R9", 0, 16'h4200, 16'h4444, 0, 8'h00, 16'h8200, 5'd1, 5'd2, 4'd8, 4'd5, 0);
    runOp("R7", 0, 16'h4300, 16'h5555, 0, 8'h00, 16'h8300, 5'd9, 5'd9, 4'd8, 4'd4, 0);
    runOp("R7", 1, 16'h4400, 16'h6666, 0, 8'h00, 16'h8400, 5'd9, 5'd9, 4'd8, 4'd0, 0);
    runOp("R8", 1, 16'h4500, 16'h7777, 0, 8'h00, 16'h8500, 5'd1, 5'd2, 4'd9, 4'd1, 0);
    runOp("R8", 0, 16'h4600, 16'h8888, 0, 8'h00, 16'h8600, 5'd1, 5'd2, 4'd0, 4'd0, 0);
    runOp("R10", 0, 16'h4700, 16'h9999, 1, 8'hF0, 16'h8700, 5'd1, 5'd2, 4'd8, 4'd0, 0);
    runOp("R11", 1, 16'h4800, 16'hABCD, 0, 8'h00, 16'h8800, 5'd1, 5'd2, 4'd8, 4'd0, 1);
    curReq = "R2";
    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule